// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a memory-mapped watchdog counter. After software starts it, a 32-bit count falls by one on every clock. When the count reaches zero the block raises an expiry interrupt and the count stays at zero. Software keeps the system alive by rewriting the count before that happens. This rewrite is the refresh, or ping. An optional threshold raises an early-warning interrupt some cycles before expiry. Software can use that warning to refresh the count or to log the event before the final timeout.

The count, threshold and enable registers are guarded by a key. A write to one of them is accepted only when the bus write just before it put the unlock key into the key register. Every bus write uses up the key, whether or not that write was to a guarded register. A guarded write that arrives without a fresh key is dropped and changes nothing. Both interrupts are latched in a status register, and software clears them by writing ones to that register. The status write needs no key.

Registers by byte offset: 0x00 count (the refresh value on write, the live count on read), 0x04 threshold, 0x08 enable (bit 0), 0x0C key, 0x10 status (bit 8 is the early warning, bit 9 is the expiry). The unlock key is 0xF1D0DEAD.

Top module: `guard_timer`

## Requirements
- R1: After reset the count reads 0xFFFFFFFF, the enable bit, the threshold and both status bits read 0, both interrupt outputs are low, and no key is held.
- R2: A write to offset 0x00, 0x04 or 0x08 takes effect only if the bus write just before it wrote 0xF1D0DEAD to offset 0x0C. Any bus write uses up the key. A guarded write without a fresh key changes no state.
- R3: While enable bit 0 (offset 0x08) is 1, the count falls by one on each clock. While it is 0, the count holds its value.
- R4: Reads are registered. bus_rdata shows, one clock later, the register selected by bus_addr: the live count at 0x00, the threshold at 0x04, the enable bit in bit 0 at 0x08, zero at 0x0C, and the status bits at bits 8 and 9 of 0x10.
- R5: A keyed write to offset 0x00 reloads the count with the written value, and this write is the refresh.
- R6: Status bit 8 sets on the clock edge where the block is enabled and the count equals a nonzero threshold. A threshold of 0 never sets it.
- R7: Status bit 9 sets on the clock edge where the block is enabled and the count is 0. The count then stays at 0 until it is reloaded.
- R8: A write to offset 0x10 clears each status bit whose position in the written data is 1. This write needs no key. If a set and a clear of the same bit fall on the same edge, the set wins.
- R9: irq_early always equals status bit 8, and irq_expire always equals status bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's bus_addr |
| irq_early | output | 1 | Early-warning interrupt, level |
| irq_expire | output | 1 | Expiry interrupt, level |

## Verification
The bench sweeps every load value from 1 to 8 against every threshold from 0 up to that load, and checks on each cycle that each interrupt rises on exactly the predicted edge. An off-by-one in the compare or the decrement moves an edge and shows up immediately. A design that treats a zero threshold as live would raise a warning when the count reaches zero.

The key gate is probed with several cases: a wrong key, a key that is used up by a status write, and a second write made after one keyed write. A gate that keeps the key for more than one write would let the enable or threshold change where it must not.

The remaining checks cover the status register and the count. Expiry is cleared while the block is stopped, and a same-edge set/clear is tried while the block is still running. A design where clear beats set would drop the interrupt while the count still sits at zero. The bench also checks that the count holds at zero after expiry, so a counter that wraps to 0xFFFFFFFF is caught.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_COUNT  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_THRESH = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_KEY    = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h10;
  localparam int ST_EARLY_BIT  = 8;
  localparam int ST_EXPIRE_BIT = 9;
  localparam int NUM_IRQ = 2;
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'hF1D0DEAD
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_i,
  input  logic [wdg_pkg::ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic                      unlock_o
);
  logic armed_q;

  // Any write uses up the key; only a key write re-arms the gate.
  always_ff @(posedge clk) begin
    if (rst) armed_q <= 1'b0;
    else if (wr_i) armed_q <= (addr_i == wdg_pkg::OFS_KEY) && (wdata_i == KEY);
  end

  assign unlock_o = armed_q;
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  output logic [DATA_W-1:0] count_o,
  output logic              zero_o
);
  logic [DATA_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '1;
    else if (load_i) cnt_q <= load_val_i;
    else if (run_i && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
  end

  assign count_o = cnt_q;
  assign zero_o  = (cnt_q == '0);
endmodule

// File: rtl/wdg_status.sv
module wdg_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    // A set and a clear on the same edge: the set wins.
    always_ff @(posedge clk) begin
      if (rst) bit_q <= 1'b0;
      else if (set_i[i]) bit_q <= 1'b1;
      else if (clr_i[i]) bit_q <= 1'b0;
    end
    assign stat_o[i] = bit_q;
  end
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'hF1D0DEAD
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic [wdg_pkg::ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic                       irq_early,
  output logic                       irq_expire
);
  import wdg_pkg::*;

  logic              key_ok;
  logic              wr_count, wr_thresh, wr_enable, wr_status;
  logic [DATA_W-1:0] thresh_q;
  logic              enable_q;
  logic [DATA_W-1:0] count;
  logic              count_zero;
  logic [NUM_IRQ-1:0] st_set, st_clr, st_q;

  wdg_key_gate #(.DATA_W(DATA_W), .KEY(KEY)) u_key (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .unlock_o(key_ok)
  );

  assign wr_count  = bus_wr && key_ok && (bus_addr == OFS_COUNT);
  assign wr_thresh = bus_wr && key_ok && (bus_addr == OFS_THRESH);
  assign wr_enable = bus_wr && key_ok && (bus_addr == OFS_ENABLE);
  assign wr_status = bus_wr && (bus_addr == OFS_STATUS);

  always_ff @(posedge clk) begin
    if (rst) begin
      thresh_q <= '0;
      enable_q <= 1'b0;
    end else begin
      if (wr_thresh) thresh_q <= bus_wdata;
      if (wr_enable) enable_q <= bus_wdata[0];
    end
  end

  wdg_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .run_i(enable_q), .load_i(wr_count),
    .load_val_i(bus_wdata), .count_o(count), .zero_o(count_zero)
  );

  // Status index 0 is the early warning, index 1 is expiry.
  assign st_set[0] = enable_q && (thresh_q != '0) && (count == thresh_q);
  assign st_set[1] = enable_q && count_zero;
  assign st_clr[0] = wr_status && bus_wdata[ST_EARLY_BIT];
  assign st_clr[1] = wr_status && bus_wdata[ST_EXPIRE_BIT];

  wdg_status #(.N(NUM_IRQ)) u_st (
    .clk(clk), .rst(rst), .set_i(st_set), .clr_i(st_clr), .stat_o(st_q)
  );

  assign irq_early  = st_q[0];
  assign irq_expire = st_q[1];

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      bus_rdata <= '0;
      case (bus_addr)
        OFS_COUNT:  bus_rdata <= count;
        OFS_THRESH: bus_rdata <= thresh_q;
        OFS_ENABLE: bus_rdata[0] <= enable_q;
        OFS_STATUS: begin
          bus_rdata[ST_EARLY_BIT]  <= st_q[0];
          bus_rdata[ST_EXPIRE_BIT] <= st_q[1];
        end
        default: bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 32'hF1D0DEAD
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr,
  input logic [wdg_pkg::ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic                       key_ok,
  input logic                       enable_q,
  input logic [DATA_W-1:0]          thresh_q,
  input logic [DATA_W-1:0]          count,
  input logic                       irq_early,
  input logic                       irq_expire
);
  import wdg_pkg::*;

  p_key_consumed_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !(bus_addr == OFS_KEY && bus_wdata == KEY)) |=> !key_ok);

  p_locked_enable_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !key_ok && bus_addr == OFS_ENABLE) |=> $stable(enable_q));

  p_count_falls_r3: assert property (@(posedge clk) disable iff (rst)
    (enable_q && count != '0 && !(bus_wr && key_ok && bus_addr == OFS_COUNT))
    |=> (count == $past(count) - 1'b1));

  p_count_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (!enable_q && !(bus_wr && key_ok && bus_addr == OFS_COUNT)) |=> $stable(count));

  p_early_needs_thresh_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_early) |-> ($past(thresh_q) != '0));

  p_zero_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (count == '0 && !(bus_wr && key_ok && bus_addr == OFS_COUNT)) |=> (count == '0));

  p_expire_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_expire && !(bus_wr && bus_addr == OFS_STATUS)) |=> irq_expire);
endmodule

bind guard_timer guard_timer_chk #(.DATA_W(DATA_W), .KEY(KEY)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .key_ok(key_ok), .enable_q(enable_q),
  .thresh_q(thresh_q), .count(count), .irq_early(irq_early),
  .irq_expire(irq_expire)
);

// File: tb/guard_timer_tb_top.sv
module guard_timer_tb_top;
  localparam logic [31:0] KEY = 32'hF1D0DEAD;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_early, irq_expire;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  guard_timer dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_early(irq_early), .irq_expire(irq_expire)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bus_wr = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic kwr(input logic [4:0] a, input logic [31:0] d);
    wr(5'h0C, KEY);
    wr(a, d);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] v, v2;
    do_reset();
    // R1 reset state
    rd(5'h00, v); check("R1 count", v, 32'hFFFFFFFF);
    rd(5'h04, v); check("R1 thresh", v, 0);
    rd(5'h08, v); check("R1 enable", v, 0);
    rd(5'h10, v); check("R1 status", v, 0);
    check("R1 irqs", {30'd0, irq_early, irq_expire}, 0);
    rd(5'h0C, v); check("R4 key reads zero", v, 0);

    // R2 key gate cases
    wr(5'h08, 1); rd(5'h08, v); check("R2 no key", v, 0);
    wr(5'h0C, 32'h12345678); wr(5'h08, 1); rd(5'h08, v); check("R2 wrong key", v, 0);
    wr(5'h0C, KEY); wr(5'h10, 0); wr(5'h08, 1); rd(5'h08, v); check("R2 used by status", v, 0);
    kwr(5'h04, 7); wr(5'h04, 9); rd(5'h04, v); check("R2 second write", v, 7);
    wr(5'h0C, KEY); rd(5'h00, v); wr(5'h00, 5); rd(5'h00, v); check("R2 key kept across read", v, 5);

    // R3/R4 live count and freeze
    do_reset();
    kwr(5'h00, 1000); kwr(5'h08, 1);
    rd(5'h00, v); repeat (5) @(negedge clk); rd(5'h00, v2);
    check("R3 R4 count falls", v - v2, 6);
    kwr(5'h08, 0);
    rd(5'h00, v); repeat (7) @(negedge clk); rd(5'h00, v2);
    check("R3 frozen", v2, v);
    rd(5'h08, v); check("R4 enable read", v, 0);
    // R5 refresh while running
    kwr(5'h08, 1); kwr(5'h00, 32'hFFFFFFFF);
    rd(5'h00, v); check("R5 reload max", v, 32'hFFFFFFFF);

    // R6/R7/R9 sweep over load and threshold
    for (int n = 1; n <= 8; n++) begin
      for (int t = 0; t <= n; t++) begin
        do_reset();
        kwr(5'h04, t); kwr(5'h00, n); kwr(5'h08, 1);
        for (int m = 1; m <= n + 2; m++) begin
          @(negedge clk);
          check("R6 early", irq_early, (t != 0 && m >= n - t + 1));
          check("R7 expire", irq_expire, (m >= n + 1));
        end
      end
    end

    // R7 hold at zero, R8 set beats clear, R8/R9 clear
    rd(5'h00, v); check("R7 holds zero", v, 0);
    wr(5'h10, 32'h200); check("R8 set wins", irq_expire, 1);
    kwr(5'h08, 0); @(negedge clk);
    wr(5'h10, 32'h200);
    check("R8 R9 expire cleared", irq_expire, 0);
    check("R8 early kept", irq_early, 1);
    rd(5'h10, v); check("R4 R8 status read", v, 32'h100);
    wr(5'h10, 32'h100);
    check("R9 early cleared", irq_early, 0);
    rd(5'h00, v); check("R7 still zero", v, 0);
    kwr(5'h00, 3); rd(5'h00, v); check("R5 reload after expiry", v, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule